// File: doc/BRIEF.md
# Oversampled NRZI Bit-Clock Recovery

This block rebuilds the receive bit clock from the one-bit output of a tone demodulator and turns the NRZI-coded line into 16-bit data words. A programmable timer produces sample strobes. The interval between strobes is a whole number of timer units, and each unit lasts `UNIT_CYCLES` clock cycles. The block runs in one of two modes: three samples per nominal bit with a 4-unit interval, or two samples per nominal bit with a 6-unit interval. At the nominal 1200 bit/s this gives 3600 or 2400 samples per second.

Every sample records whether the line changed since the previous sample, and this is kept in a short transition history. On a bit-decision sample the block reads that history. It makes the next interval one unit longer when the edge arrived late, and one unit shorter when it arrived early, so the decision point drifts towards the bit centre. The decision sample also decodes one NRZI bit. These bits are collected least significant bit first in a register that carries a marker bit instead of a counter. A full word appears on `word_data` with a one-cycle `word_valid` pulse.

A signed counter records the net number of late minus early corrections. A once-per-second strobe clears it. The mode is taken only while the block is halted (`run_en` low). The line input is assumed to be already synchronous to `clk`.

Top module: `nrzi_cdr`

## Requirements
- R1: After reset, `word_valid` is 0, `word_data` is 0 and `corr_count` is 0. The first sample after `run_en` rises is a bit-decision sample, and the NRZI reference level and previous-sample level are both 0.
- R2: No sample strobe occurs while `run_en` is low. The first strobe occurs in the cycle `run_en` is high, and consecutive strobes are separated by exactly (interval units × `UNIT_CYCLES`) clock cycles.
- R3: In three-sample mode (`spb_sel` = 0), every third sample is a decision sample, and the interval after any sample that is not corrected is 4 units.
- R4: In three-sample mode, the decision sample examines the 3-bit history (bit 0 = change at this sample, bit 1 = one sample earlier, bit 2 = two earlier). Value 3'b001 is late: the next interval is 5 units and `corr_count` rises by 1. Value 3'b100 is early: the next interval is 3 units and `corr_count` falls by 1.
- R5: In two-sample mode (`spb_sel` = 1), decision and intermediate samples alternate and the nominal interval is 6 units. On a decision sample, history bits [1:0] = 2'b01 give 7 units and +1 to `corr_count`, and 2'b10 give 5 units and −1. Any other value keeps 6 units.
- R6: On each decision sample the decoded bit is 1 if the line equals the level captured at the previous decision sample, and 0 otherwise.
- R7: Decoded bits fill a word least significant bit first. After the 16th bit, `word_data` holds the word and `word_valid` is high for exactly one cycle, starting the cycle after that decision sample. The next word starts empty.
- R8: `corr_count` changes only on sample strobes with a correction. A `sec_tick` clears it to 0 on the next cycle and takes priority over any correction.
- R9: `spb_sel` is taken only while `run_en` is low. Changes while running have no effect on intervals or decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Enables sampling; low halts the block and admits a mode change |
| spb_sel | input | 1 | Samples per bit: 0 = three, 1 = two |
| rx_line | input | 1 | Demodulated receive line |
| sec_tick | input | 1 | Once-per-second strobe clearing the correction counter |
| sample_strobe | output | 1 | High in the cycle a line sample is taken |
| word_data | output | WORD_W | Last completed word, first bit in bit 0 |
| word_valid | output | 1 | One-cycle pulse when `word_data` is updated |
| corr_count | output | CORR_W | Signed net late-minus-early correction count |

## Verification
The bench builds the block with `UNIT_CYCLES` = 2 and the default word and counter widths. Each unit of timing correction therefore shows up as exactly two clock cycles in the gap between strobes, and a complete 16-bit word arrives within a few hundred cycles in either mode. This keeps the 3-, 4-, 5-, 6- and 7-unit intervals cheap to tell apart. Both word boundaries, the early and late history patterns and the mode lock-out can all be reached in one short run.

// File: rtl/nrzi_cdr_pkg.sv
package nrzi_cdr_pkg;

    typedef enum logic {
        SPB_THREE = 1'b0,
        SPB_TWO   = 1'b1
    } spb_mode_e;

    typedef enum logic [1:0] {
        ADJ_NONE  = 2'd0,
        ADJ_LATE  = 2'd1,
        ADJ_EARLY = 2'd2
    } adj_e;

    localparam int UNITS_W   = 3;
    localparam int MAX_UNITS = 7;
    localparam int HIST_W    = 3;

    typedef struct packed {
        logic               decide;
        adj_e               adj;
        logic [UNITS_W-1:0] units;
    } slot_plan_t;

    // Index of the last sample slot inside one nominal bit.
    function automatic logic [1:0] last_slot(spb_mode_e m);
        return (m == SPB_TWO) ? 2'd1 : 2'd2;
    endfunction

    // Decide the length of the interval that follows the current sample.
    function automatic slot_plan_t plan_slot(spb_mode_e m, logic decide,
                                             logic [HIST_W-1:0] h);
        slot_plan_t p;
        p.decide = decide;
        p.adj    = ADJ_NONE;
        if (m == SPB_THREE) begin
            p.units = UNITS_W'(4);
            if (decide && h == 3'b001) begin
                p.adj   = ADJ_LATE;
                p.units = UNITS_W'(5);
            end else if (decide && h == 3'b100) begin
                p.adj   = ADJ_EARLY;
                p.units = UNITS_W'(3);
            end
        end else begin
            p.units = UNITS_W'(6);
            if (decide && h[1:0] == 2'b01) begin
                p.adj   = ADJ_LATE;
                p.units = UNITS_W'(7);
            end else if (decide && h[1:0] == 2'b10) begin
                p.adj   = ADJ_EARLY;
                p.units = UNITS_W'(5);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/nrzi_interval_timer.sv
module nrzi_interval_timer
    import nrzi_cdr_pkg::*;
#(
    parameter int UNIT_CYCLES = 1736
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run_en,
    input  logic [UNITS_W-1:0] units,
    output logic               tick
);
    localparam int CNT_W = $clog2(MAX_UNITS * UNIT_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;

    assign tick   = run_en && (cnt_q == '0);
    assign reload = CNT_W'(units) * CNT_W'(UNIT_CYCLES) - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/nrzi_phase_track.sv
module nrzi_phase_track
    import nrzi_cdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  spb_mode_e  mode,
    input  logic       line,
    output slot_plan_t plan,
    output logic       bit_en,
    output logic       bit_val
);
    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_nx;
    logic              prev_smp_q;
    logic              prev_dec_q;
    logic [1:0]        slot_q;
    logic              decide;

    assign hist_nx = {hist_q[HIST_W-2:0], line ^ prev_smp_q};
    assign decide  = (slot_q == 2'd0);
    assign plan    = plan_slot(mode, decide, hist_nx);
    assign bit_en  = tick && decide;
    assign bit_val = (line == prev_dec_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q     <= '0;
            prev_smp_q <= 1'b0;
            prev_dec_q <= 1'b0;
            slot_q     <= 2'd0;
        end else if (tick) begin
            hist_q     <= hist_nx;
            prev_smp_q <= line;
            if (decide) begin
                prev_dec_q <= line;
            end
            slot_q <= (slot_q >= last_slot(mode)) ? 2'd0 : slot_q + 2'd1;
        end
    end
endmodule

// File: rtl/nrzi_word_pack.sv
module nrzi_word_pack #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              bit_val,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid
);
    localparam logic [WORD_W:0] EMPTY = {1'b1, {WORD_W{1'b0}}};

    logic [WORD_W:0]   acc_q;
    logic [WORD_W:0]   acc_nx;
    logic [WORD_W-1:0] word_q;
    logic              valid_q;

    // New bits enter at the top; the marker reaching bit 0 means full.
    assign acc_nx     = {bit_val, acc_q[WORD_W:1]};
    assign word_data  = word_q;
    assign word_valid = valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= EMPTY;
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (bit_en) begin
                if (acc_nx[0]) begin
                    word_q  <= acc_nx[WORD_W:1];
                    valid_q <= 1'b1;
                    acc_q   <= EMPTY;
                end else begin
                    acc_q <= acc_nx;
                end
            end
        end
    end
endmodule

// File: rtl/nrzi_cdr.sv
module nrzi_cdr
    import nrzi_cdr_pkg::*;
#(
    parameter int UNIT_CYCLES = 1736,
    parameter int WORD_W      = 16,
    parameter int CORR_W      = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     run_en,
    input  logic                     spb_sel,
    input  logic                     rx_line,
    input  logic                     sec_tick,
    output logic                     sample_strobe,
    output logic [WORD_W-1:0]        word_data,
    output logic                     word_valid,
    output logic signed [CORR_W-1:0] corr_count
);
    spb_mode_e            mode_q;
    slot_plan_t           plan;
    logic                 tick;
    logic                 bit_en;
    logic                 bit_val;
    logic signed [CORR_W-1:0] corr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= SPB_THREE;
        end else if (!run_en) begin
            mode_q <= spb_mode_e'(spb_sel);
        end
    end

    nrzi_interval_timer #(.UNIT_CYCLES(UNIT_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .units  (plan.units),
        .tick   (tick)
    );

    nrzi_phase_track u_track (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .mode    (mode_q),
        .line    (rx_line),
        .plan    (plan),
        .bit_en  (bit_en),
        .bit_val (bit_val)
    );

    nrzi_word_pack #(.WORD_W(WORD_W)) u_pack (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .bit_val    (bit_val),
        .word_data  (word_data),
        .word_valid (word_valid)
    );

    always_ff @(posedge clk) begin
        if (rst || sec_tick) begin
            corr_q <= '0;
        end else if (tick && plan.adj == ADJ_LATE) begin
            corr_q <= corr_q + CORR_W'(1);
        end else if (tick && plan.adj == ADJ_EARLY) begin
            corr_q <= corr_q - CORR_W'(1);
        end
    end

    assign sample_strobe = tick;
    assign corr_count    = corr_q;
endmodule

// File: rtl/nrzi_cdr_checker.sv
module nrzi_cdr_checker #(
    parameter int CORR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              run_en,
    input logic              sec_tick,
    input logic              sample_strobe,
    input logic              word_valid,
    input logic [CORR_W-1:0] corr_count,
    input logic              mode_q
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!word_valid && corr_count == '0));

    assert_no_strobe_halted_R2: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> !sample_strobe);

    assert_valid_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    assert_valid_follows_sample_R7: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(sample_strobe));

    assert_corr_cleared_R8: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> (corr_count == '0));

    assert_corr_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!sec_tick && !sample_strobe) |=> $stable(corr_count));

    assert_mode_locked_R9: assert property (@(posedge clk) disable iff (rst)
        run_en |=> $stable(mode_q));
endmodule

bind nrzi_cdr nrzi_cdr_checker #(.CORR_W(CORR_W)) u_checker (
    .clk           (clk),
    .rst           (rst),
    .run_en        (run_en),
    .sec_tick      (sec_tick),
    .sample_strobe (sample_strobe),
    .word_valid    (word_valid),
    .corr_count    (corr_count),
    .mode_q        (mode_q)
);

// File: tb/tb_nrzi_cdr.sv
module tb_nrzi_cdr;
    localparam int U      = 2;
    localparam int WORD_W = 16;
    localparam int CORR_W = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_en = 1'b0;
    logic spb_sel = 1'b0;
    logic rx_line = 1'b0;
    logic sec_tick = 1'b0;
    logic sample_strobe;
    logic [WORD_W-1:0] word_data;
    logic word_valid;
    logic signed [CORR_W-1:0] corr_count;

    int compared = 0;
    int mismatched = 0;
    int words_seen = 0;
    logic [WORD_W-1:0] last_word = '0;

    always #4 clk = ~clk;

    nrzi_cdr #(.UNIT_CYCLES(U), .WORD_W(WORD_W), .CORR_W(CORR_W)) dut (
        .clk(clk), .rst(rst), .run_en(run_en), .spb_sel(spb_sel),
        .rx_line(rx_line), .sec_tick(sec_tick), .sample_strobe(sample_strobe),
        .word_data(word_data), .word_valid(word_valid), .corr_count(corr_count)
    );

    always @(negedge clk) begin
        if (word_valid) begin
            words_seen = words_seen + 1;
            last_word  = word_data;
        end
    end

    // {mode, line level, expected interval units, expected correction count}
    localparam logic [6:0] VEC [22] = '{
        7'b0_0_100_00, 7'b0_0_100_00, 7'b0_0_100_00, 7'b0_1_101_01,
        7'b0_1_100_01, 7'b0_1_100_01, 7'b0_1_100_01, 7'b0_0_100_01,
        7'b0_0_100_01, 7'b0_0_011_00, 7'b0_0_100_00, 7'b0_1_100_00,
        7'b0_1_100_00,
        7'b1_0_110_00, 7'b1_0_110_00, 7'b1_1_111_01, 7'b1_1_110_01,
        7'b1_1_110_01, 7'b1_0_110_01, 7'b1_0_101_00, 7'b1_0_110_00,
        7'b1_0_110_00
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        compared = compared + 1;
        if (!ok) begin
            mismatched = mismatched + 1;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic start_run(input logic m);
        rst = 1'b1;
        run_en = 1'b0;
        spb_sel = m;
        rx_line = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        run_en = 1'b1;
        #1;
    endtask

    // Called while a strobe is pending; sets the level it samples and
    // measures the gap to the following strobe.
    task automatic step(input logic lvl, input int exp_units, input string req);
        int n = 0;
        rx_line = lvl;
        do begin
            @(negedge clk);
            n = n + 1;
        end while (!sample_strobe && n < 100);
        check(n == exp_units * U, req, n, exp_units * U);
    endtask

    initial begin
        #(200000 * 8);
        mismatched = mismatched + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int strobes;
        int words_before;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(word_valid == 1'b0, "R1 word_valid", int'(word_valid), 0);
        check(word_data == '0, "R1 word_data", int'(word_data), 0);
        check(corr_count == '0, "R1 corr_count", int'(corr_count), 0);
        rst = 1'b0;
        strobes = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (sample_strobe) strobes = strobes + 1;
        end
        check(strobes == 0, "R2 no strobe while halted", strobes, 0);

        words_before = 0;
        for (int i = 0; i < 22; i++) begin
            logic m;
            logic lvl;
            int gap;
            int corr;
            string req;
            m    = VEC[i][6];
            lvl  = VEC[i][5];
            gap  = int'(VEC[i][4:2]);
            corr = int'(VEC[i][1:0]);
            if (i == 0 || i == 13) begin
                start_run(m);
                check(sample_strobe == 1'b1, "R2 first strobe on enable", int'(sample_strobe), 1);
                words_before = words_seen;
            end
            if (m == 1'b0) req = (gap == 4) ? "R3 interval" : "R4 corrected interval";
            else req = "R5 interval";
            step(lvl, gap, req);
            check(int'(corr_count) == corr, "R8 correction count", int'(corr_count), corr);
            if (i == 12) begin
                spb_sel = 1'b1; // R9: must be ignored while running
                for (int k = 0; k < 33; k++) step(1'b1, 4, "R9 mode held, R3 interval");
                check(words_seen == words_before + 1, "R7 one word", words_seen - words_before, 1);
                check(last_word == 16'hFFE5, "R6 R7 three-sample word", int'(last_word), 'hFFE5);
            end
            if (i == 21) begin
                for (int k = 0; k < 22; k++) step(1'b0, 6, "R5 interval");
                check(words_seen == words_before + 1, "R7 one word", words_seen - words_before, 1);
                check(last_word == 16'hFFF5, "R6 R7 two-sample word", int'(last_word), 'hFFF5);
            end
        end

        // R8: clear strobe after a late correction
        start_run(1'b0);
        step(1'b1, 5, "R4 late at first decision");
        check(int'(corr_count) == 1, "R8 count after late", int'(corr_count), 1);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        check(corr_count == '0, "R8 cleared by sec_tick", int'(corr_count), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule